// File: doc/BRIEF.md
# Sampling Phase Tuning Sweep Controller

This block runs the complete receive-clock tuning procedure for a high-speed card interface. When started, it first decides whether tuning is needed at all. If it is, it resets the delay line and then walks through every sampling phase in turn. At each phase it programs the delay line and issues a tuning read. The returned byte stream is compared on the fly against a fixed known pattern held in an on-chip ROM. The result is a pass mask with one bit per phase.

A separate selector picks the phase from that mask, and the controller then programs the chosen phase as its final step. If a sweep produces an empty mask, the whole sweep is repeated up to a fixed limit before an I/O failure is reported. An error reported by the delay-line sequencer or by the selector aborts the run at once.

All neighbours use level request / done handshakes. A request stays high until its done or error input is seen. The card protocol engine that performs the read is outside this block.

Top module: `tune_sweep`

## Requirements
- R1: A start with `clkMhz` not above 100, or with `timingMode` other than 1 (HS200) or 2 (SDR104), completes with `status` 0 (OK) and issues no delay-line, phase or read request.
- R2: The expected pattern is 64 bytes long. It is 128 bytes when `cmdOpcode` equals 21 and `bus8Bit` is 1. Bytes are taken from the 32-bit pattern words least significant byte first, and a read passes only if it delivers exactly that many bytes.
- R3: Each sweep starts with one delay-line init. Phases 0 to 15 are then programmed in ascending order, and each read request begins only after its phase has been programmed.
- R4: A phase passes only if no beat carries `rxErr` and every byte matches the pattern. A mismatch does not end the read: the request stays high until the beat with `rxLast`.
- R5: When a sweep passes no phase, the sweep is repeated, up to 3 sweeps in total. After the third empty sweep the run ends with `status` 1 (I/O failure) and `passMask` 0.
- R6: With a non-empty mask, `selReq` is raised while `passMask` shows the mask. The `selPhase` returned is programmed through the phase handshake, and the run ends with `status` 0 and `finalPhase` equal to that phase.
- R7: `dllErr`, `phaseErr` or `selErr` seen during its handshake ends the run on the next cycle with `status` 2 (hardware error).
- R8: `done` is a one-cycle pulse per run. `start` is ignored while a run is in progress, and at most one of the four requests is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a tuning run (idle only) |
| clkMhz | input | 10 | Current card clock in MHz |
| timingMode | input | 2 | 0 other, 1 HS200, 2 SDR104, 3 other |
| cmdOpcode | input | 6 | Tuning command opcode |
| bus8Bit | input | 1 | Bus is 8 bits wide |
| dllReq | output | 1 | Delay-line reset/init request |
| dllDone | input | 1 | Delay-line init finished |
| dllErr | input | 1 | Delay-line init failed |
| phaseReq | output | 1 | Program phase request |
| phaseVal | output | 4 | Phase to program |
| phaseDone | input | 1 | Phase programmed |
| phaseErr | input | 1 | Phase programming failed |
| readReq | output | 1 | Tuning read request, held until last beat |
| rxValid | input | 1 | Received byte valid |
| rxData | input | 8 | Received byte |
| rxLast | input | 1 | Final byte of the read |
| rxErr | input | 1 | Command or data error on this read |
| selReq | output | 1 | Phase selection request |
| selDone | input | 1 | Selection finished |
| selPhase | input | 4 | Selected phase |
| selErr | input | 1 | Selection failed |
| done | output | 1 | Run finished (one cycle) |
| status | output | 2 | 0 OK, 1 I/O failure, 2 hardware error |
| passMask | output | 16 | Per-phase pass bits of the last sweep |
| finalPhase | output | 4 | Phase programmed at the end (0 if none) |

## Verification
The bench builds the block with its defaults: 16 phases and a limit of 3 sweeps. With these values the full retry ladder of 48 reads, and both the 64-byte and 128-byte pattern lengths, finish within a few thousand cycles. Bench models of the delay line, read engine and selector can corrupt a chosen byte per phase, flag an error on a chosen phase, or return a short stream. This lets the bench check the mask edges at phases 0 and 15, a wrong stream length, and every abort path.

// File: rtl/tune_pkg.sv
package tune_pkg;

  localparam int PAT_SMALL_BYTES = 64;
  localparam int PAT_LARGE_BYTES = 128;

  // Known tuning patterns, sent least significant byte of each word first.
  localparam logic [31:0] PAT_SMALL [16] = '{
    32'h00ff0fff, 32'hccc3ccff, 32'hffcc3cc3, 32'heffefffe,
    32'hddffdfff, 32'hfbfffbff, 32'hff7fffbf, 32'hefbdf777,
    32'hf0fff0ff, 32'h3cccfc0f, 32'hcfcc33cc, 32'heeffefff,
    32'hfdfffdff, 32'hffbfffdf, 32'hfff7ffbb, 32'hde7b7ff7};

  localparam logic [31:0] PAT_LARGE [32] = '{
    32'hff00ffff, 32'h0000ffff, 32'hccccffff, 32'hcccc33cc,
    32'hcc3333cc, 32'hffffcccc, 32'hffffeeff, 32'hffeeeeff,
    32'hffddffff, 32'hddddffff, 32'hbbffffff, 32'hbbffffff,
    32'hffffffbb, 32'hffffff77, 32'h77ff7777, 32'hffeeddbb,
    32'h00ffffff, 32'h00ffffff, 32'hccffff00, 32'hcc33cccc,
    32'h3333cccc, 32'hffcccccc, 32'hffeeffff, 32'heeeeffff,
    32'hddffffff, 32'hddffffff, 32'hffffffdd, 32'hffffffbb,
    32'hffffbbbb, 32'hffff77ff, 32'hff7777ff, 32'heeddbb77};

  typedef enum logic [1:0] {
    STAT_OK     = 2'd0,
    STAT_IOFAIL = 2'd1,
    STAT_HWERR  = 2'd2
  } tuneStat_e;

  typedef enum logic [3:0] {
    S_IDLE, S_DLL, S_SETPH, S_READ, S_NEXT, S_EVAL, S_SEL, S_FINAL, S_DONE
  } tuneState_e;

  typedef struct packed {
    logic runStart;
    logic sweepStart;
    logic readStart;
    logic beatEn;
    logic recordPhase;
    logic latchSel;
  } tuneStb_t;

endpackage

// File: rtl/tune_datapath.sv
module tune_datapath
  import tune_pkg::*;
#(
  parameter int NUM_PHASES   = 16,
  parameter int MAX_SWEEPS   = 3,
  parameter int HS200_OPCODE = 21
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  tuneStb_t                      stb,
  input  logic [5:0]                    cmdOpcode,
  input  logic                          bus8Bit,
  input  logic [7:0]                    rxData,
  input  logic                          rxLast,
  input  logic                          rxErr,
  input  logic [$clog2(NUM_PHASES)-1:0] selPhase,
  output logic                          lastPhase,
  output logic                          maskEmpty,
  output logic                          sweepsLeft,
  output logic [NUM_PHASES-1:0]         passMask,
  output logic [$clog2(NUM_PHASES)-1:0] curPhase,
  output logic [$clog2(NUM_PHASES)-1:0] chosenPhase
);

  localparam int PW = $clog2(NUM_PHASES);
  localparam int SW = $clog2(MAX_SWEEPS + 1);

  logic            bigQ;
  logic [7:0]      byteCnt;
  logic            failQ;
  logic [PW-1:0]   phaseQ;
  logic [SW-1:0]   sweepQ;
  logic [NUM_PHASES-1:0] maskQ;
  logic [PW-1:0]   selQ;

  logic [7:0]  patLen;
  logic [31:0] patWord;
  logic [7:0]  expByte;
  logic        beatBad;

  always_comb begin
    patLen  = bigQ ? 8'(PAT_LARGE_BYTES) : 8'(PAT_SMALL_BYTES);
    patWord = bigQ ? PAT_LARGE[byteCnt[6:2]] : PAT_SMALL[byteCnt[5:2]];
    expByte = 8'(patWord >> {byteCnt[1:0], 3'b000});
    beatBad = rxErr || (rxData != expByte) || (byteCnt >= patLen) ||
              (rxLast && (byteCnt != patLen - 8'd1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bigQ    <= 1'b0;
      byteCnt <= '0;
      failQ   <= 1'b0;
      phaseQ  <= '0;
      sweepQ  <= '0;
      maskQ   <= '0;
      selQ    <= '0;
    end else begin
      if (stb.runStart) begin
        bigQ   <= (cmdOpcode == 6'(HS200_OPCODE)) && bus8Bit;
        sweepQ <= '0;
        maskQ  <= '0;
        selQ   <= '0;
      end
      if (stb.sweepStart) begin
        maskQ  <= '0;
        phaseQ <= '0;
        sweepQ <= sweepQ + SW'(1);
      end
      if (stb.readStart) begin
        byteCnt <= '0;
        failQ   <= 1'b0;
      end
      if (stb.beatEn) begin
        if (byteCnt != 8'hff) byteCnt <= byteCnt + 8'd1;
        if (beatBad) failQ <= 1'b1;
      end
      if (stb.recordPhase) begin
        maskQ[phaseQ] <= !failQ;
        phaseQ        <= phaseQ + PW'(1);
      end
      if (stb.latchSel) selQ <= selPhase;
    end
  end

  assign lastPhase   = (phaseQ == PW'(NUM_PHASES - 1));
  assign maskEmpty   = (maskQ == '0);
  assign sweepsLeft  = (sweepQ < SW'(MAX_SWEEPS));
  assign passMask    = maskQ;
  assign curPhase    = phaseQ;
  assign chosenPhase = selQ;

endmodule

// File: rtl/tune_ctrl.sv
module tune_ctrl
  import tune_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       needTune,
  input  logic       dllDone,
  input  logic       dllErr,
  input  logic       phaseDone,
  input  logic       phaseErr,
  input  logic       rxValid,
  input  logic       rxLast,
  input  logic       selDone,
  input  logic       selErr,
  input  logic       lastPhase,
  input  logic       maskEmpty,
  input  logic       sweepsLeft,
  output tuneStb_t   stb,
  output logic       dllReq,
  output logic       phaseReq,
  output logic       finalSel,
  output logic       readReq,
  output logic       selReq,
  output logic       done,
  output logic [1:0] status
);

  tuneState_e stateQ, stateD;
  tuneStat_e  statQ, statD;

  always_comb begin
    stateD = stateQ;
    statD  = statQ;
    stb    = '0;
    unique case (stateQ)
      S_IDLE: if (start) begin
        stb.runStart = 1'b1;
        if (needTune) stateD = S_DLL;
        else begin stateD = S_DONE; statD = STAT_OK; end
      end
      S_DLL: begin
        if (dllErr) begin stateD = S_DONE; statD = STAT_HWERR; end
        else if (dllDone) begin stb.sweepStart = 1'b1; stateD = S_SETPH; end
      end
      S_SETPH: begin
        if (phaseErr) begin stateD = S_DONE; statD = STAT_HWERR; end
        else if (phaseDone) begin stb.readStart = 1'b1; stateD = S_READ; end
      end
      S_READ: begin
        stb.beatEn = rxValid;
        if (rxValid && rxLast) stateD = S_NEXT;
      end
      S_NEXT: begin
        stb.recordPhase = 1'b1;
        stateD = lastPhase ? S_EVAL : S_SETPH;
      end
      S_EVAL: begin
        if (!maskEmpty) stateD = S_SEL;
        else if (sweepsLeft) stateD = S_DLL;
        else begin stateD = S_DONE; statD = STAT_IOFAIL; end
      end
      S_SEL: begin
        if (selErr) begin stateD = S_DONE; statD = STAT_HWERR; end
        else if (selDone) begin stb.latchSel = 1'b1; stateD = S_FINAL; end
      end
      S_FINAL: begin
        if (phaseErr) begin stateD = S_DONE; statD = STAT_HWERR; end
        else if (phaseDone) begin stateD = S_DONE; statD = STAT_OK; end
      end
      S_DONE:  stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      statQ  <= STAT_OK;
    end else begin
      stateQ <= stateD;
      statQ  <= statD;
    end
  end

  assign dllReq   = (stateQ == S_DLL);
  assign phaseReq = (stateQ == S_SETPH) || (stateQ == S_FINAL);
  assign finalSel = (stateQ == S_FINAL);
  assign readReq  = (stateQ == S_READ);
  assign selReq   = (stateQ == S_SEL);
  assign done     = (stateQ == S_DONE);
  assign status   = statQ;

endmodule

// File: rtl/tune_sweep.sv
module tune_sweep
  import tune_pkg::*;
#(
  parameter int NUM_PHASES   = 16,
  parameter int MAX_SWEEPS   = 3,
  parameter int MHZ_W        = 10,
  parameter int MIN_TUNE_MHZ = 100,
  parameter int HS200_OPCODE = 21
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [MHZ_W-1:0]              clkMhz,
  input  logic [1:0]                    timingMode,
  input  logic [5:0]                    cmdOpcode,
  input  logic                          bus8Bit,
  output logic                          dllReq,
  input  logic                          dllDone,
  input  logic                          dllErr,
  output logic                          phaseReq,
  output logic [$clog2(NUM_PHASES)-1:0] phaseVal,
  input  logic                          phaseDone,
  input  logic                          phaseErr,
  output logic                          readReq,
  input  logic                          rxValid,
  input  logic [7:0]                    rxData,
  input  logic                          rxLast,
  input  logic                          rxErr,
  output logic                          selReq,
  input  logic                          selDone,
  input  logic [$clog2(NUM_PHASES)-1:0] selPhase,
  input  logic                          selErr,
  output logic                          done,
  output logic [1:0]                    status,
  output logic [NUM_PHASES-1:0]         passMask,
  output logic [$clog2(NUM_PHASES)-1:0] finalPhase
);

  localparam int PW = $clog2(NUM_PHASES);

  tuneStb_t      stb;
  logic          needTune, lastPhase, maskEmpty, sweepsLeft, finalSel;
  logic [PW-1:0] curPhase, chosenPhase;

  assign needTune = (clkMhz > MHZ_W'(MIN_TUNE_MHZ)) &&
                    ((timingMode == 2'd1) || (timingMode == 2'd2));

  tune_ctrl u_ctrl (
    .clk, .rstN, .start, .needTune,
    .dllDone, .dllErr, .phaseDone, .phaseErr,
    .rxValid, .rxLast, .selDone, .selErr,
    .lastPhase, .maskEmpty, .sweepsLeft,
    .stb, .dllReq, .phaseReq, .finalSel, .readReq, .selReq,
    .done, .status
  );

  tune_datapath #(
    .NUM_PHASES(NUM_PHASES), .MAX_SWEEPS(MAX_SWEEPS), .HS200_OPCODE(HS200_OPCODE)
  ) u_dp (
    .clk, .rstN, .stb, .cmdOpcode, .bus8Bit,
    .rxData, .rxLast, .rxErr, .selPhase,
    .lastPhase, .maskEmpty, .sweepsLeft, .passMask,
    .curPhase, .chosenPhase
  );

  assign phaseVal   = finalSel ? chosenPhase : curPhase;
  assign finalPhase = chosenPhase;

endmodule

// File: rtl/tune_sweep_chk.sv
module tune_sweep_chk #(
  parameter int NUM_PHASES = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  dllReq,
  input logic                  dllErr,
  input logic                  phaseReq,
  input logic                  phaseDone,
  input logic                  phaseErr,
  input logic                  readReq,
  input logic                  selReq,
  input logic                  selErr,
  input logic                  done,
  input logic [1:0]            status,
  input logic [NUM_PHASES-1:0] passMask
);

  a_r8_one_request: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dllReq, phaseReq, readReq, selReq}));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r3_read_after_phase: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readReq) |-> $past(phaseReq && phaseDone));

  a_r6_select_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    selReq |-> (passMask != '0));

  a_r5_iofail_empty: assert property (@(posedge clk) disable iff (!rstN)
    (done && status == 2'd1) |-> (passMask == '0));

  a_r7_dll_abort: assert property (@(posedge clk) disable iff (!rstN)
    (dllReq && dllErr) |=> (done && status == 2'd2));

  a_r7_phase_abort: assert property (@(posedge clk) disable iff (!rstN)
    (phaseReq && phaseErr) |=> (done && status == 2'd2));

  a_r7_sel_abort: assert property (@(posedge clk) disable iff (!rstN)
    (selReq && selErr) |=> (done && status == 2'd2));

endmodule

bind tune_sweep tune_sweep_chk #(.NUM_PHASES(NUM_PHASES)) u_chk (
  .clk(clk), .rstN(rstN), .dllReq(dllReq), .dllErr(dllErr),
  .phaseReq(phaseReq), .phaseDone(phaseDone), .phaseErr(phaseErr),
  .readReq(readReq), .selReq(selReq), .selErr(selErr),
  .done(done), .status(status), .passMask(passMask)
);

// File: tb/tune_sweep_tb.sv
module tune_sweep_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic start = 0, bus8Bit = 0;
  logic [9:0] clkMhz = 0;
  logic [1:0] timingMode = 0;
  logic [5:0] cmdOpcode = 0;
  logic dllReq, phaseReq, readReq, selReq, done;
  logic dllDone = 0, dllErr = 0, phaseDone = 0, phaseErr = 0;
  logic rxValid = 0, rxLast = 0, rxErr = 0;
  logic [7:0] rxData = 0;
  logic selDone = 0, selErr = 0;
  logic [3:0] selPhase = 0, phaseVal, finalPhase;
  logic [1:0] status;
  logic [15:0] passMask;

  tune_sweep u_dut (.*);

  localparam logic [31:0] W64 [16] = '{
    32'h00ff0fff, 32'hccc3ccff, 32'hffcc3cc3, 32'heffefffe,
    32'hddffdfff, 32'hfbfffbff, 32'hff7fffbf, 32'hefbdf777,
    32'hf0fff0ff, 32'h3cccfc0f, 32'hcfcc33cc, 32'heeffefff,
    32'hfdfffdff, 32'hffbfffdf, 32'hfff7ffbb, 32'hde7b7ff7};
  localparam logic [31:0] W128 [32] = '{
    32'hff00ffff, 32'h0000ffff, 32'hccccffff, 32'hcccc33cc,
    32'hcc3333cc, 32'hffffcccc, 32'hffffeeff, 32'hffeeeeff,
    32'hffddffff, 32'hddddffff, 32'hbbffffff, 32'hbbffffff,
    32'hffffffbb, 32'hffffff77, 32'h77ff7777, 32'hffeeddbb,
    32'h00ffffff, 32'h00ffffff, 32'hccffff00, 32'hcc33cccc,
    32'h3333cccc, 32'hffcccccc, 32'hffeeffff, 32'heeeeffff,
    32'hddffffff, 32'hddffffff, 32'hffffffdd, 32'hffffffbb,
    32'hffffbbbb, 32'hffff77ff, 32'hff7777ff, 32'heeddbb77};

  // bench-side configuration of the neighbour models
  int cfgLen = 64;
  bit cfgBig = 0;
  logic [15:0] cfgGood = 16'hffff;
  int cfgErrPhase = -1;
  int cfgPhaseErrAt = -1;
  bit cfgDllErr = 0, cfgSelErr = 0;
  logic [3:0] cfgSel = 0;

  int checks = 0, failures = 0;
  int dllCount = 0, readCount = 0, doneCount = 0, earlyDrop = 0, logN = 0;
  int phLog [64];
  logic [15:0] seenMask = 0;
  logic [1:0] gotStat;
  logic [15:0] gotMask;
  logic [3:0] gotPhase;
  bit finished = 0;

  function automatic logic [7:0] patByte(bit big, int i);
    logic [31:0] w;
    w = big ? W128[(i / 4) % 32] : W64[(i / 4) % 16];
    return w[8 * (i % 4) +: 8];
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // delay-line model
  initial forever begin
    @(negedge clk);
    if (dllReq && !dllDone) begin dllDone = 1; dllErr = cfgDllErr; dllCount++; end
    else begin dllDone = 0; dllErr = 0; end
  end

  // phase programming model
  initial forever begin
    @(negedge clk);
    if (phaseReq && !phaseDone) begin
      phaseDone = 1;
      phaseErr  = (cfgPhaseErrAt == int'(phaseVal));
      if (logN < 64) phLog[logN] = int'(phaseVal);
      logN++;
    end else begin phaseDone = 0; phaseErr = 0; end
  end

  // selector model
  initial forever begin
    @(negedge clk);
    if (selReq && !selDone) begin
      selDone = 1; selErr = cfgSelErr; selPhase = cfgSel; seenMask = passMask;
    end else begin selDone = 0; selErr = 0; end
  end

  // read engine model
  initial forever begin
    @(negedge clk);
    if (readReq) begin
      int ph;
      ph = (logN > 0 && logN <= 64) ? phLog[logN - 1] : 0;
      readCount++;
      for (int i = 0; i < cfgLen; i++) begin
        if (i > 0 && !readReq) earlyDrop++;
        rxValid = 1;
        rxData  = patByte(cfgBig, i) ^ ((!cfgGood[ph] && i == 5) ? 8'h01 : 8'h00);
        rxLast  = (i == cfgLen - 1);
        rxErr   = (cfgErrPhase == ph) && (i == cfgLen - 1);
        @(negedge clk);
      end
      rxValid = 0; rxLast = 0; rxErr = 0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (done) doneCount++;
  end

  task automatic clearLogs();
    dllCount = 0; readCount = 0; earlyDrop = 0; logN = 0; seenMask = 0;
  endtask

  task automatic runTune(int mhz, int mode, int opc, bit b8);
    clearLogs();
    clkMhz = 10'(mhz); timingMode = 2'(mode); cmdOpcode = 6'(opc); bus8Bit = b8;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int t = 0; t < 20000 && !done; t++) @(negedge clk);
    gotStat = status; gotMask = passMask; gotPhase = finalPhase;
    @(negedge clk);
  endtask

  task automatic setCfg(int len, bit big, logic [15:0] good);
    cfgLen = len; cfgBig = big; cfgGood = good;
    cfgErrPhase = -1; cfgPhaseErrAt = -1; cfgDllErr = 0; cfgSelErr = 0;
  endtask

  task automatic t_reset();
    chk("R8", "done after reset", int'(done), 0);
    chk("R8", "requests after reset", int'({dllReq, phaseReq, readReq, selReq}), 0);
    chk("R8", "status after reset", int'(status), 0);
    chk("R5", "mask after reset", int'(passMask), 0);
  endtask

  task automatic t_skip();
    setCfg(64, 0, 16'hffff);
    runTune(100, 1, 21, 0);
    chk("R1", "status at 100MHz", int'(gotStat), 0);
    chk("R1", "dll inits at 100MHz", dllCount, 0);
    chk("R1", "reads at 100MHz", readCount, 0);
    runTune(200, 3, 19, 0);
    chk("R1", "status other mode", int'(gotStat), 0);
    chk("R1", "phase requests other mode", logN, 0);
    runTune(101, 2, 19, 0);
    chk("R1", "SDR104 at 101MHz tunes", dllCount, 1);
  endtask

  task automatic t_sweep64();
    setCfg(64, 0, 16'h0ff0); cfgSel = 4'd7;
    runTune(200, 1, 21, 0);
    chk("R6", "status", int'(gotStat), 0);
    chk("R4", "mask", int'(gotMask), 16'h0ff0);
    chk("R6", "mask at selector", int'(seenMask), 16'h0ff0);
    chk("R6", "final phase", int'(gotPhase), 7);
    chk("R3", "dll inits", dllCount, 1);
    chk("R3", "phase programs", logN, 17);
    for (int i = 0; i < 16; i++) chk("R3", "phase order", phLog[i], i);
    chk("R6", "last programmed phase", phLog[16], 7);
    chk("R4", "reads", readCount, 16);
    chk("R4", "stream drained", earlyDrop, 0);
  endtask

  task automatic t_pattern128();
    setCfg(128, 1, 16'h8001); cfgSel = 4'd15;
    runTune(200, 2, 21, 1);
    chk("R2", "128-byte mask edges", int'(gotMask), 16'h8001);
    chk("R6", "final phase 15", int'(gotPhase), 15);
    setCfg(64, 0, 16'h0003); cfgSel = 4'd0;
    runTune(200, 1, 21, 0);
    chk("R2", "opcode 21 on narrow bus uses 64", int'(gotMask), 16'h0003);
  endtask

  task automatic t_retry();
    setCfg(64, 0, 16'hffff);
    runTune(200, 1, 21, 1);
    chk("R2", "short stream status", int'(gotStat), 1);
    chk("R5", "sweeps", dllCount, 3);
    chk("R5", "reads over three sweeps", readCount, 48);
    chk("R5", "empty mask", int'(gotMask), 0);
    setCfg(65, 0, 16'hffff);
    runTune(200, 1, 19, 0);
    chk("R2", "extra byte status", int'(gotStat), 1);
    setCfg(64, 0, 16'h0000);
    runTune(200, 2, 19, 0);
    chk("R5", "all corrupt status", int'(gotStat), 1);
    chk("R4", "corrupt streams drained", earlyDrop, 0);
    chk("R5", "final phase none", int'(gotPhase), 0);
  endtask

  task automatic t_rxErr();
    setCfg(64, 0, 16'h000f); cfgErrPhase = 3; cfgSel = 4'd1;
    runTune(200, 1, 19, 0);
    chk("R4", "rxErr phase fails", int'(gotMask), 16'h0007);
  endtask

  task automatic t_hwErr();
    setCfg(64, 0, 16'hffff); cfgDllErr = 1;
    runTune(200, 1, 19, 0);
    chk("R7", "dll error status", int'(gotStat), 2);
    chk("R7", "no read after dll error", readCount, 0);
    setCfg(64, 0, 16'hffff); cfgPhaseErrAt = 4;
    runTune(200, 1, 19, 0);
    chk("R7", "phase error status", int'(gotStat), 2);
    chk("R7", "reads before phase error", readCount, 4);
    setCfg(64, 0, 16'hffff); cfgSelErr = 1;
    runTune(200, 1, 19, 0);
    chk("R7", "selector error status", int'(gotStat), 2);
  endtask

  task automatic t_busyStart();
    int d0;
    setCfg(64, 0, 16'h00f0); cfgSel = 4'd5;
    d0 = doneCount;
    clearLogs();
    clkMhz = 10'd200; timingMode = 2'd1; cmdOpcode = 6'd19; bus8Bit = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (200) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    for (int t = 0; t < 20000 && !done; t++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R8", "single done", doneCount - d0, 1);
    chk("R8", "start ignored while busy", dllCount, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    repeat (2) @(negedge clk);
    t_skip();
    t_sweep64();
    t_pattern128();
    t_retry();
    t_rxErr();
    t_hwErr();
    t_busyStart();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule